// File: doc/BRIEF.md
# Row/Column FFT Pass Sequencer

This block controls a two-pass DFT of size N = N1*N2 laid out as an N1-row by N2-column matrix. It first loads N samples, taken from a valid/ready stream, into an input buffer in row-major order. It then runs the column pass, which is N2 transforms of length N1. The column pass reads the input buffer and writes a working memory. Each point written in that pass carries the twiddle index pair (i, k) that the datapath uses for W_N^(i*k). Last comes the row pass, which is N1 transforms of length N2. The row pass reads the working memory back and writes an output buffer, so the final bins are stored in column-major order.

The arithmetic, the coefficient storage and the memories themselves are outside the block. The sequencer only supplies addresses, strobes, twiddle indices, phase indication and a completion pulse. A start pulse arms a run. Once loading begins, the only back-pressure is that the load stalls on gaps in the input stream. The two passes then run at one point per cycle with no stalls.

Top module: `fft_rc_seq`

## Requirements
- R1: After reset the phase output is 0 (idle), and in_ready, rd_en, wr_en, tw_valid, seg_first, seg_last and done are all 0. While the block is idle, in_valid has no effect on any output.
- R2: A start pulse seen in idle moves phase to 1 (load) on the next cycle. A start pulse in any other phase is ignored and leaves the sequence unchanged.
- R3: In load, in_ready is 1, and a sample is accepted in every cycle where in_valid and in_ready are both 1. The n-th accepted sample (counting from 0) drives wr_en=1 with wr_addr=n, which is row r, column c at address r*N2+c. In a load cycle with in_valid low, wr_en is 0 and the address does not advance. in_ready is 0 in every other phase.
- R4: The cycle after the last sample is accepted, phase becomes 2 (column pass) for exactly N cycles. Column c (0..N2-1) is the outer loop and row i (0..N1-1) is the inner loop. rd_addr and wr_addr both equal i*N2+c, and rd_en and wr_en are both 1. In this pass the reads target the input buffer and the writes target the working memory.
- R5: tw_valid is 1 only in the column pass, with tw_i=i and tw_k=c for the point being written. At all other times tw_valid is 0 and tw_i and tw_k are 0.
- R6: After the column pass, phase becomes 3 (row pass) for exactly N cycles. Row r is the outer loop and position j (0..N2-1) is the inner loop. rd_addr is r*N2+j, which reads the working memory. wr_addr is j*N1+r, which writes the output buffer in column-major order. tw_valid is 0 throughout.
- R7: In both passes, seg_first is 1 on the first point of each short transform and seg_last is 1 on its last point. Both are 0 in idle and in load.
- R8: The cycle after the last row-pass write, done is 1 for exactly one cycle with phase 0. The block is then idle again and accepts a new start.
- R9: Whenever wr_en or rd_en is 1, the corresponding address is below N1*N2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, honoured only in idle |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Sequencer accepts a sample (load phase) |
| phase | output | 2 | 0 idle, 1 load, 2 column pass, 3 row pass |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | clog2(N1*N2) | Read address |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | clog2(N1*N2) | Write address |
| tw_valid | output | 1 | Twiddle index valid |
| tw_i | output | clog2(N1) | Twiddle row index i |
| tw_k | output | clog2(N2) | Twiddle column index k |
| seg_first | output | 1 | First point of a short transform |
| seg_last | output | 1 | Last point of a short transform |
| done | output | 1 | One-cycle completion pulse |

## Verification
All outputs are decoded combinationally from registered state. A start edge shows up as phase 1 one cycle later. In load, wr_en and wr_addr follow in_valid in the same cycle. The first column-pass point appears one cycle after the last accepted sample. The row pass follows directly, and done follows the last row point by one cycle. The bench drives its inputs at the falling edge and checks one nanosecond later, so each check sees exactly one registered step. It walks the complete address and twiddle sequence for a 16x16 and a 4x4 instance. Its own gap patterns stall the load, and it injects stray start pulses during every phase.

// File: rtl/fft_rc_seq_pkg.sv
package fft_rc_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_COL, ST_ROW, ST_FIN} seq_state_e;
  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_LOAD = 2'd1;
  localparam logic [1:0] PH_COL  = 2'd2;
  localparam logic [1:0] PH_ROW  = 2'd3;
endpackage

// File: rtl/fft_rc_nest_cnt.sv
// Two-level counter: inner runs 0..inner_max, outer steps on inner wrap.
// Both wrap to zero together after the final point.
module fft_rc_nest_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] inner_max,
  input  logic [W-1:0] outer_max,
  output logic [W-1:0] inner,
  output logic [W-1:0] outer,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      inner <= '0;
      outer <= '0;
    end else if (en) begin
      if (inner == inner_max) begin
        inner <= '0;
        outer <= (outer == outer_max) ? '0 : outer + 1'b1;
      end else begin
        inner <= inner + 1'b1;
      end
    end
  end

  assign last = (inner == inner_max) && (outer == outer_max);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable({inner, outer}));  // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (inner <= inner_max && outer <= outer_max));  // R9
endmodule

// File: rtl/fft_rc_seq_fsm.sv
module fft_rc_seq_fsm
  import fft_rc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic       last,
  output seq_state_e state,
  output logic       cnt_en,
  output logic       cnt_clr
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start)            nxt = ST_LOAD;
      ST_LOAD: if (in_valid && last) nxt = ST_COL;
      ST_COL:  if (last)             nxt = ST_ROW;
      ST_ROW:  if (last)             nxt = ST_FIN;
      ST_FIN:                        nxt = ST_IDLE;
      default:                       nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    cnt_en  = (state == ST_COL) || (state == ST_ROW) || (state == ST_LOAD && in_valid);
    cnt_clr = (state == ST_IDLE) || (state == ST_FIN);
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> state == ST_IDLE);  // R2
  AST_FIN_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> $past(state) == ST_ROW);  // R8
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |=> state == ST_IDLE);  // R8
endmodule

// File: rtl/fft_rc_seq_addr.sv
// Maps the counter position to memory addresses, twiddle indices and strobes.
module fft_rc_seq_addr
  import fft_rc_seq_pkg::*;
#(
  parameter int N1 = 16,
  parameter int N2 = 16,
  localparam int AW  = $clog2(N1 * N2),
  localparam int IBW = $clog2(N1),
  localparam int KBW = $clog2(N2),
  localparam int CW  = (IBW > KBW) ? IBW : KBW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  seq_state_e     state,
  input  logic           in_valid,
  input  logic [CW-1:0]  inner,
  input  logic [CW-1:0]  outer,
  input  logic [CW-1:0]  inner_max,
  output logic [1:0]     phase,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic           tw_valid,
  output logic [IBW-1:0] tw_i,
  output logic [KBW-1:0] tw_k,
  output logic           seg_first,
  output logic           seg_last
);
  localparam logic [AW-1:0] N1_A = AW'(N1);
  localparam logic [AW-1:0] N2_A = AW'(N2);

  logic [AW-1:0] in_a, out_a;
  assign in_a  = AW'(inner);
  assign out_a = AW'(outer);

  always_comb begin
    phase     = PH_IDLE;
    rd_en     = 1'b0;
    rd_addr   = '0;
    wr_en     = 1'b0;
    wr_addr   = '0;
    tw_valid  = 1'b0;
    tw_i      = '0;
    tw_k      = '0;
    seg_first = 1'b0;
    seg_last  = 1'b0;
    unique case (state)
      ST_LOAD: begin
        phase   = PH_LOAD;
        wr_en   = in_valid;
        wr_addr = out_a * N2_A + in_a;       // row-major fill
      end
      ST_COL: begin
        phase     = PH_COL;
        rd_en     = 1'b1;
        wr_en     = 1'b1;
        rd_addr   = in_a * N2_A + out_a;     // row i, column c
        wr_addr   = in_a * N2_A + out_a;
        tw_valid  = 1'b1;
        tw_i      = IBW'(inner);
        tw_k      = KBW'(outer);
        seg_first = (inner == '0);
        seg_last  = (inner == inner_max);
      end
      ST_ROW: begin
        phase     = PH_ROW;
        rd_en     = 1'b1;
        wr_en     = 1'b1;
        rd_addr   = out_a * N2_A + in_a;     // row r, position j
        wr_addr   = in_a * N1_A + out_a;     // column-major result
        seg_first = (inner == '0);
        seg_last  = (inner == inner_max);
      end
      default: ;
    endcase
  end

  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < N1 * N2));  // R9
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < N1 * N2));  // R9
  AST_TW_COL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> (phase == PH_COL && int'(tw_i) < N1 && int'(tw_k) < N2));  // R5
endmodule

// File: rtl/fft_rc_seq.sv
module fft_rc_seq
  import fft_rc_seq_pkg::*;
#(
  parameter int N1 = 16,
  parameter int N2 = 16,
  localparam int AW  = $clog2(N1 * N2),
  localparam int IBW = $clog2(N1),
  localparam int KBW = $clog2(N2),
  localparam int CW  = (IBW > KBW) ? IBW : KBW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           in_valid,
  output logic           in_ready,
  output logic [1:0]     phase,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic           tw_valid,
  output logic [IBW-1:0] tw_i,
  output logic [KBW-1:0] tw_k,
  output logic           seg_first,
  output logic           seg_last,
  output logic           done
);
  localparam logic [CW-1:0] N1_M = CW'(N1 - 1);
  localparam logic [CW-1:0] N2_M = CW'(N2 - 1);

  seq_state_e    state;
  logic          cnt_en, cnt_clr, last;
  logic [CW-1:0] inner, outer, inner_max, outer_max;

  // Column pass runs rows inside columns; load and row pass run the other way.
  always_comb begin
    if (state == ST_COL) begin
      inner_max = N1_M;
      outer_max = N2_M;
    end else begin
      inner_max = N2_M;
      outer_max = N1_M;
    end
  end

  fft_rc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .last(last),
    .state(state), .cnt_en(cnt_en), .cnt_clr(cnt_clr)
  );

  fft_rc_nest_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .inner_max(inner_max), .outer_max(outer_max),
    .inner(inner), .outer(outer), .last(last)
  );

  fft_rc_seq_addr #(.N1(N1), .N2(N2)) u_addr (
    .clk(clk), .rst_n(rst_n), .state(state), .in_valid(in_valid),
    .inner(inner), .outer(outer), .inner_max(inner_max),
    .phase(phase), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .tw_valid(tw_valid), .tw_i(tw_i), .tw_k(tw_k),
    .seg_first(seg_first), .seg_last(seg_last)
  );

  assign in_ready = (state == ST_LOAD);
  assign done     = (state == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (wr_en && phase == PH_LOAD));  // R3
  AST_READY_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !rd_en && !tw_valid);  // R3
endmodule

// File: tb/sim_fft_rc_seq.sv
module sim_fft_rc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  bit   sel = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  // 16x16 instance
  logic       rdy0, rde0, wre0, twv0, sf0, sl0, dn0;
  logic [1:0] ph0;
  logic [7:0] rda0, wra0;
  logic [3:0] ti0, tk0;
  // 4x4 instance
  logic       rdy1, rde1, wre1, twv1, sf1, sl1, dn1;
  logic [1:0] ph1;
  logic [3:0] rda1, wra1;
  logic [1:0] ti1, tk1;

  fft_rc_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start && !sel), .in_valid(in_valid && !sel),
    .in_ready(rdy0), .phase(ph0), .rd_en(rde0), .rd_addr(rda0), .wr_en(wre0), .wr_addr(wra0),
    .tw_valid(twv0), .tw_i(ti0), .tw_k(tk0), .seg_first(sf0), .seg_last(sl0), .done(dn0)
  );

  fft_rc_seq #(.N1(4), .N2(4)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start && sel), .in_valid(in_valid && sel),
    .in_ready(rdy1), .phase(ph1), .rd_en(rde1), .rd_addr(rda1), .wr_en(wre1), .wr_addr(wra1),
    .tw_valid(twv1), .tw_i(ti1), .tw_k(tk1), .seg_first(sf1), .seg_last(sl1), .done(dn1)
  );

  int o_rdy, o_ph, o_rde, o_rda, o_wre, o_wra, o_twv, o_ti, o_tk, o_sf, o_sl, o_dn;
  always_comb begin
    o_rdy = sel ? int'(rdy1) : int'(rdy0);
    o_ph  = sel ? int'(ph1)  : int'(ph0);
    o_rde = sel ? int'(rde1) : int'(rde0);
    o_rda = sel ? int'(rda1) : int'(rda0);
    o_wre = sel ? int'(wre1) : int'(wre0);
    o_wra = sel ? int'(wra1) : int'(wra0);
    o_twv = sel ? int'(twv1) : int'(twv0);
    o_ti  = sel ? int'(ti1)  : int'(ti0);
    o_tk  = sel ? int'(tk1)  : int'(tk0);
    o_sf  = sel ? int'(sf1)  : int'(sf0);
    o_sl  = sel ? int'(sl1)  : int'(sl0);
    o_dn  = sel ? int'(dn1)  : int'(dn0);
  end

  task automatic ceq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_quiet(input string req);
    ceq({req, " phase"}, o_ph, 0);
    ceq({req, " in_ready"}, o_rdy, 0);
    ceq({req, " rd_en"}, o_rde, 0);
    ceq({req, " wr_en"}, o_wre, 0);
    ceq({req, " tw_valid"}, o_twv, 0);
    ceq({req, " seg"}, o_sf + o_sl, 0);
  endtask

  // One full run; drive at negedge, check 1 ns later.
  task automatic run_cfg(input int n1, input int n2, input int gap_mod);
    int n;
    int cyc;
    bit v;
    @(negedge clk);
    in_valid = 1'b1;                              // R1: valid in idle ignored
    #1;
    check_quiet("R1 idle");
    ceq("R1 done idle", o_dn, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // Load phase with gaps and stray start pulses
    n = 0;
    cyc = 0;
    while (n < n1 * n2) begin
      v = (cyc % gap_mod) != 1;
      in_valid = v;
      start = (cyc % 7) == 3;                     // R2: ignored outside idle
      #1;
      ceq("R2 phase load", o_ph, 1);
      ceq("R3 in_ready", o_rdy, 1);
      ceq("R3 wr_en", o_wre, int'(v));
      if (v) ceq("R3 load addr", o_wra, n);
      ceq("R7 seg in load", o_sf + o_sl, 0);
      ceq("R5 tw in load", o_twv, 0);
      if (v) n++;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    // Column pass
    for (int c = 0; c < n2; c++) begin
      for (int i = 0; i < n1; i++) begin
        start = ((c + i) % 5) == 0;
        #1;
        ceq("R4 phase col", o_ph, 2);
        ceq("R3 ready col", o_rdy, 0);
        ceq("R4 rd_en", o_rde, 1);
        ceq("R4 wr_en", o_wre, 1);
        ceq("R4 rd_addr", o_rda, i * n2 + c);
        ceq("R4 wr_addr", o_wra, i * n2 + c);
        ceq("R5 tw_valid", o_twv, 1);
        ceq("R5 tw_i", o_ti, i);
        ceq("R5 tw_k", o_tk, c);
        ceq("R7 first col", o_sf, int'(i == 0));
        ceq("R7 last col", o_sl, int'(i == n1 - 1));
        @(negedge clk);
      end
    end
    // Row pass
    for (int r = 0; r < n1; r++) begin
      for (int j = 0; j < n2; j++) begin
        start = ((r + j) % 4) == 1;
        #1;
        ceq("R6 phase row", o_ph, 3);
        ceq("R6 rd_en", o_rde, 1);
        ceq("R6 wr_en", o_wre, 1);
        ceq("R6 rd_addr", o_rda, r * n2 + j);
        ceq("R6 wr_addr", o_wra, j * n1 + r);
        ceq("R6 tw off", o_twv, 0);
        ceq("R5 tw_i zero", o_ti + o_tk, 0);
        ceq("R7 first row", o_sf, int'(j == 0));
        ceq("R7 last row", o_sl, int'(j == n2 - 1));
        @(negedge clk);
      end
    end
    start = 1'b1;                                 // R2: ignored in done cycle
    #1;
    ceq("R8 done", o_dn, 1);
    check_quiet("R8 done cycle");
    @(negedge clk);
    start = 1'b0;
    #1;
    ceq("R8 done single", o_dn, 0);
    check_quiet("R8 back idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_quiet("R1 reset u0");
    ceq("R1 reset done", o_dn, 0);
    sel = 1'b1;
    #1;
    check_quiet("R1 reset u1");
    sel = 1'b0;
    run_cfg(16, 16, 4);
    sel = 1'b1;
    run_cfg(4, 4, 3);
    run_cfg(4, 4, 2);                             // R8: restart after done
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule